// File: doc/BRIEF.md
# Auto-Stepping Accumulator Pointer Unit

This block keeps the index of the working accumulator, one of sixteen, and sends it to the accumulator file. Software sets the index through a small register port. A control register can make the index move by one after every arithmetic or logic operation. The datapath reports each finished operation with a one-cycle strobe. The control register picks the direction of the step and the size of a power-of-two window. Only the pointer bits inside that window wrap. The bits above the window keep their value.

The register port has one select line. Select 0 addresses the pointer register and select 1 addresses the control register. A write takes effect on the clock edge that samples it. A read returns the registered contents of the selected register in the same cycle. A clear request, an automatic step and a direct pointer write can arrive in the same cycle. A fixed priority decides which one lands: reset, then clear, then step, then direct write.

Top module: `acc_ptr_unit`

## Requirements
- R1: After a synchronous active-low reset, both registers read 0x00 and `acc_sel` is 0.
- R2: A write with `reg_sel`=0 stores `reg_wdata[3:0]` as the pointer and ignores bits 7:4. A read of the pointer returns the pointer in bits 3:0 and zeros in bits 7:4. `acc_sel` always equals the stored pointer.
- R3: A write with `reg_sel`=1 stores bit 6 as the step direction (0 = up, 1 = down) and bits 2:0 as the window mode. Reading the control register returns these fields in the same positions. Bits 7 and 5:3 always read 0.
- R4: A control write with bit 7 set forces the pointer to 0 on that edge. The clear bit is never stored and always reads 0.
- R5: With direction up, each `op_done` pulse adds one to the pointer inside the window: mode 1 is 2 values, mode 2 is 4, mode 3 is 8 and mode 4 is 16. Pointer bits above the window are unchanged.
- R6: With direction down, each `op_done` pulse subtracts one inside the same window and wraps downward, with the upper bits unchanged.
- R7: With mode 0 the pointer never steps, whatever the direction bit holds. A direct pointer write still applies in a cycle that carries `op_done`.
- R8: Modes 5, 6 and 7 step exactly as mode 4 (a window of 16).
- R9: When `op_done` and a direct pointer write come in the same cycle and stepping is enabled, the step is applied and the written value is discarded.
- R10: When `op_done` and a control write with bit 7 set come in the same cycle, the pointer becomes 0 and no step is applied.
- R11: Without `op_done`, a clear request or a pointer write, the pointer holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_sel | input | 1 | Register select for reads and writes: 0 = pointer, 1 = control |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered contents of the selected register |
| op_done | input | 1 | One-cycle pulse marking a finished arithmetic or logic operation |
| acc_sel | output | 4 | Current accumulator index |

## Verification
The embedded properties check these behaviours on every cycle:
- a clear request always leaves the pointer at zero;
- a pointer with no pending event holds its value;
- an enabled step overrides a coincident write;
- mode 0 freezes the pointer under `op_done`;
- any enabled step changes the pointer.

Other results depend on the exact numbers and can only be shown by the bench scenarios:
- the window arithmetic;
- upper-bit preservation;
- the fold of modes 5 to 7 onto mode 4;
- the read-back masking of reserved bits.

To show these, the bench sweeps every start pointer, every direction and every mode, and compares each result with a value it computes itself.

// File: rtl/accp_pkg.sv
// Package: shared definitions for the accumulator pointer unit.
// Assumes a single register select bit addressing two registers.
package accp_pkg;

    // Register select encoding on the register port
    typedef enum logic {
        SEL_PTR  = 1'b0,
        SEL_CTRL = 1'b1
    } accp_sel_e;

    // Number of low pointer bits inside the stepping window for a mode value
    function automatic int win_bits(input int mode, input int ptr_w);
        if (mode <= 0)
            return 0;
        else if (mode >= ptr_w)
            return ptr_w;
        else
            return mode;
    endfunction

endpackage

// File: rtl/accp_ctrl_reg.sv
// Module: control register holding step direction and window mode.
// Produces a combinational clear request on a control write with the
// clear bit set; the clear bit itself is never stored (reads back 0).
// Assumes the reserved bits are simply not stored.
module accp_ctrl_reg #(
    parameter int DATA_W  = 8,
    parameter int MODE_W  = 3,
    parameter int CLR_BIT = 7,
    parameter int DIR_BIT = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic              dir_dn,
    output logic [MODE_W-1:0] mode,
    output logic              clr_req,
    output logic [DATA_W-1:0] rdata
);

    logic              dir_q;
    logic [MODE_W-1:0] mode_q;

    // Purpose: capture direction and mode fields on a control write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q  <= 1'b0;
            mode_q <= '0;
        end else if (wr_en) begin
            dir_q  <= wdata[DIR_BIT];
            mode_q <= wdata[MODE_W-1:0];
        end
    end

    // Purpose: clear is a one-cycle request, derived only from the write
    assign clr_req = wr_en & wdata[CLR_BIT];

    // Purpose: assemble read-back with reserved and clear bits forced to 0
    always_comb begin
        rdata                = '0;
        rdata[DIR_BIT]       = dir_q;
        rdata[MODE_W-1:0]    = mode_q;
    end

    assign dir_dn = dir_q;
    assign mode   = mode_q;

endmodule

// File: rtl/accp_stepper.sv
// Module: computes the next pointer value for one automatic step.
// Only bits inside the window set by the mode move; upper bits are kept.
// Assumes mode 0 means stepping is disabled and large modes saturate.
module accp_stepper
    import accp_pkg::*;
#(
    parameter int PTR_W  = 4,
    parameter int MODE_W = 3
) (
    input  logic [PTR_W-1:0]  ptr_in,
    input  logic              dir_dn,
    input  logic [MODE_W-1:0] mode,
    output logic              step_cfg_en,
    output logic [PTR_W-1:0]  ptr_next
);

    localparam logic [PTR_W-1:0] ONE = PTR_W'(1);

    int               nbits;
    logic [PTR_W-1:0] mask;
    logic [PTR_W-1:0] moved;

    // Purpose: translate the mode into a window width
    assign nbits       = win_bits(int'(mode), PTR_W);
    assign step_cfg_en = (mode != '0);

    // Purpose: one mask bit per pointer bit inside the window
    for (genvar g = 0; g < PTR_W; g++) begin : g_mask
        assign mask[g] = (g < nbits);
    end

    // Purpose: add or subtract one, then merge window bits with kept bits
    always_comb begin
        moved    = dir_dn ? (ptr_in - ONE) : (ptr_in + ONE);
        ptr_next = (ptr_in & ~mask) | (moved & mask);
    end

    // Purpose: an enabled step always changes the pointer (R5, R6)
    always_comb begin
        if (!$isunknown({mode, ptr_in, dir_dn}) && step_cfg_en)
            p_step_moves_r5: assert (ptr_next != ptr_in);
    end

endmodule

// File: rtl/accp_ptr_reg.sv
// Module: the pointer register with update priority
// clear > automatic step > direct write. Reset is handled first.
// Assumes step_req is already qualified by the operation strobe.
module accp_ptr_reg #(
    parameter int PTR_W  = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_req,
    input  logic              step_req,
    input  logic [PTR_W-1:0]  step_val,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [PTR_W-1:0]  ptr,
    output logic [DATA_W-1:0] rdata
);

    logic [PTR_W-1:0] ptr_q;

    // Purpose: update the pointer by fixed priority
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr_q <= '0;
        else if (clr_req)
            ptr_q <= '0;
        else if (step_req)
            ptr_q <= step_val;
        else if (wr_en)
            ptr_q <= wdata[PTR_W-1:0];
    end

    // Purpose: zero-extend the pointer for read-back
    assign rdata = DATA_W'(ptr_q);
    assign ptr   = ptr_q;

    // R10 and R4: a clear request always lands as zero
    p_clear_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        clr_req |=> (ptr_q == '0));

    // R9: an enabled step overrides a coincident direct write
    p_step_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_req && step_req && wr_en) |=> (ptr_q == $past(step_val)));

    // R11: with no pending event the pointer holds
    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_req && !step_req && !wr_en) |=> $stable(ptr_q));

endmodule

// File: rtl/acc_ptr_unit.sv
// Module: top of the auto-stepping accumulator pointer unit.
// Decodes the register port, qualifies stepping with the operation
// strobe and multiplexes the read-back data.
// Assumes op_done is a single-cycle pulse from the datapath.
module acc_ptr_unit
    import accp_pkg::*;
#(
    parameter int PTR_W  = 4,
    parameter int DATA_W = 8,
    parameter int MODE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_sel,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              op_done,
    output logic [PTR_W-1:0]  acc_sel
);

    localparam int CLR_BIT = DATA_W - 1;
    localparam int DIR_BIT = DATA_W - 2;

    logic              wr_ptr, wr_ctrl;
    logic              dir_dn, clr_req, step_cfg_en, step_req;
    logic [MODE_W-1:0] mode;
    logic [PTR_W-1:0]  ptr, step_val;
    logic [DATA_W-1:0] rd_ptr, rd_ctrl;

    // Purpose: route the write strobe to the selected register
    assign wr_ptr  = reg_wr && (accp_sel_e'(reg_sel) == SEL_PTR);
    assign wr_ctrl = reg_wr && (accp_sel_e'(reg_sel) == SEL_CTRL);

    accp_ctrl_reg #(
        .DATA_W (DATA_W),
        .MODE_W (MODE_W),
        .CLR_BIT(CLR_BIT),
        .DIR_BIT(DIR_BIT)
    ) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_ctrl),
        .wdata  (reg_wdata),
        .dir_dn (dir_dn),
        .mode   (mode),
        .clr_req(clr_req),
        .rdata  (rd_ctrl)
    );

    accp_stepper #(
        .PTR_W (PTR_W),
        .MODE_W(MODE_W)
    ) u_step (
        .ptr_in     (ptr),
        .dir_dn     (dir_dn),
        .mode       (mode),
        .step_cfg_en(step_cfg_en),
        .ptr_next   (step_val)
    );

    // Purpose: step only on the operation strobe with stepping enabled
    assign step_req = op_done & step_cfg_en;

    accp_ptr_reg #(
        .PTR_W (PTR_W),
        .DATA_W(DATA_W)
    ) u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_req (clr_req),
        .step_req(step_req),
        .step_val(step_val),
        .wr_en   (wr_ptr),
        .wdata   (reg_wdata),
        .ptr     (ptr),
        .rdata   (rd_ptr)
    );

    // Purpose: same-cycle read-back of the selected register
    assign reg_rdata = (accp_sel_e'(reg_sel) == SEL_CTRL) ? rd_ctrl : rd_ptr;
    assign acc_sel   = ptr;

    // R7: mode 0 freezes the pointer under an operation strobe
    p_mode0_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_done && mode == '0 && !reg_wr) |=> $stable(acc_sel));

endmodule

// File: tb/acc_ptr_unit_tb.sv
`timescale 1ns/1ps
module acc_ptr_unit_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_sel = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       op_done = 1'b0;
    logic [3:0] acc_sel;

    int tests = 0;
    int fails = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    acc_ptr_unit u_dut (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .op_done(op_done),
        .acc_sel(acc_sel)
    );

    // Expected step: window of min(mode,4) low bits, upper bits kept
    function automatic logic [3:0] model(input logic [3:0] p, input bit dn,
                                         input int mode);
        int k;
        logic [3:0] m, s;
        k = (mode == 0) ? 0 : ((mode >= 4) ? 4 : mode);
        if (k == 0) return p;
        m = 4'((1 << k) - 1);
        s = dn ? p - 4'd1 : p + 4'd1;
        return (p & ~m) | (s & m);
    endfunction

    task automatic check(input string req, input logic [7:0] act,
                         input logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    // One clock cycle of stimulus, driven at negedge, released a cycle later
    task automatic cyc(input bit wr, input bit sel, input logic [7:0] d,
                       input bit op);
        @(negedge clk);
        reg_wr = wr; reg_sel = sel; reg_wdata = d; op_done = op;
        @(negedge clk);
        reg_wr = 0; op_done = 0;
    endtask

    task automatic rd(input bit sel, output logic [7:0] v);
        reg_sel = sel;
        #1;
        v = reg_rdata;
    endtask

    initial begin
        logic [7:0] v;
        logic [3:0] e;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1 reset state
        rd(0, v); check("R1 ptr", v, 8'h00);
        rd(1, v); check("R1 ctrl", v, 8'h00);
        check("R1 acc_sel", {4'h0, acc_sel}, 8'h00);

        // R2 pointer write ignores upper bits
        cyc(1, 0, 8'hA7, 0);
        rd(0, v); check("R2 ptr read", v, 8'h07);
        check("R2 acc_sel", {4'h0, acc_sel}, 8'h07);

        // R3 and R4: all-ones control write clears pointer, masks reserved
        cyc(1, 1, 8'hFF, 0);
        rd(1, v); check("R3 ctrl read", v, 8'h47);
        rd(0, v); check("R4 clear", v, 8'h00);
        cyc(1, 1, 8'h3A, 0);
        rd(1, v); check("R3 reserved", v, 8'h02);

        // R5 R6 R7 R8: sweep mode, direction and start pointer
        for (int mode = 0; mode < 8; mode++)
            for (int dn = 0; dn < 2; dn++)
                for (int p = 0; p < 16; p++) begin
                    cyc(1, 0, 8'(p), 0);
                    cyc(1, 1, {1'b0, 1'(dn), 3'b000, 3'(mode)}, 0);
                    cyc(0, 0, 8'h00, 1);
                    e = model(4'(p), dn[0], mode);
                    rd(0, v);
                    if (mode == 0)      check("R7 mode0 hold", v, {4'h0, e});
                    else if (mode > 4)  check("R8 high mode", v, {4'h0, e});
                    else if (dn == 0)   check("R5 up", v, {4'h0, e});
                    else                check("R6 down", v, {4'h0, e});
                end

        // R6 repeated decrements in mode 3 keep bit 3
        cyc(1, 0, 8'h0A, 0);
        cyc(1, 1, 8'h43, 0);
        e = 4'hA;
        for (int i = 0; i < 4; i++) begin
            cyc(0, 0, 8'h00, 1);
            e = model(e, 1'b1, 3);
            check("R6 walk", {4'h0, acc_sel}, {4'h0, e});
        end

        // R9 step beats direct write
        cyc(1, 0, 8'h05, 0);
        cyc(1, 1, 8'h02, 0);
        cyc(1, 0, 8'h0C, 1);
        rd(0, v); check("R9 step wins", v, 8'h06);

        // R7 mode 0: direct write applies alongside op_done
        cyc(1, 1, 8'h40, 0);
        cyc(1, 0, 8'h0C, 1);
        rd(0, v); check("R7 write with mode0", v, 8'h0C);

        // R10 clear beats step
        cyc(1, 0, 8'h09, 0);
        cyc(1, 1, 8'h04, 0);
        cyc(1, 1, 8'h84, 1);
        rd(0, v); check("R10 clear wins", v, 8'h00);
        rd(1, v); check("R10 clr reads 0", v, 8'h04);

        // R11 idle cycles hold the pointer
        cyc(1, 0, 8'h0D, 0);
        repeat (5) @(negedge clk);
        rd(0, v); check("R11 hold", v, 8'h0D);

        // R1 reset after activity
        rst_n = 0;
        @(negedge clk);
        rst_n = 1;
        rd(0, v); check("R1 ptr after reset", v, 8'h00);
        rd(1, v); check("R1 ctrl after reset", v, 8'h00);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    // Watchdog
    initial begin
        #(200000 * 5);
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule